// File: doc/BRIEF.md
# Register-Mapped Bidirectional Digital Port

This block controls an 8-bit general-purpose digital port from a small register bus. Software sets each pin as an input or an output, loads the values the output pins drive, and reads either the values it loaded or the levels actually present on the pins. For each bit the block drives a tri-state pad model with a value and an output enable. The pad input is sampled through a two-stage synchronizer before it can be read.

Two bus addresses write the same output latch, so a write through either one has the same effect. The two addresses differ only on reads. The latch address returns the stored drive value, which makes read-modify-write safe when a pin is loaded or held by something outside. The port address returns the synchronized pin level. A per-bit analog-select mask turns off the digital input of a pin, so that pin reads as zero at the port address.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pad_oe` is 0, `pad_out` is 0, and `bus_rdata` is 0. Reset sets every direction bit to 1 (input), sets every analog-select bit to 1, and clears the latch.
- R2: A direction bit of 1 turns off that pin's driver (`pad_oe` bit 0). A direction bit of 0 turns on the driver (`pad_oe` bit 1). `pad_out` always carries the output latch.
- R3: A write to offset 1 (port) or offset 2 (latch) loads `bus_wdata` into the output latch. The new value is on `pad_out` from the clock edge of the write.
- R4: A read of offset 2 returns the output latch, whatever the level on `pad_in`.
- R5: A read of offset 1 returns the synchronized pin level. Read data is registered, so `bus_rdata` updates on the edge after the address is presented. A change on `pad_in` first appears in `bus_rdata` on the third rising edge after the change.
- R6: A pin whose analog-select bit is 1 reads as 0 at offset 1. This holds even when the pin is driven as an output.
- R7: Offset 0 holds the direction mask and offset 3 holds the analog-select mask. Both are written by the bus and read back unchanged.
- R8: Offsets 4 to 7 are unmapped. Reads of them return 0, and writes to them leave all four registers unchanged.
- R9: A read-modify-write through offset 2 keeps the bits it does not change, even when the pin levels disagree with the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Output enable per pin, 1 = driving |

## Verification
The main path is tried with a table of direction, latch, analog-select and external-level combinations. These include all outputs, all inputs, split masks, and analog masks that overlap driven pins. Together they separate a read that returns the pin level from one that returns the latch, and show whether the analog gate is applied after the direction mux. Alternating between the port and latch addresses for the write shows both load the same latch. A held port read around one pad edge pins the synchronizer delay to exactly two stages. A contention case, where external drivers pull pins low, shows the latch read and read-modify-write ignore the pin level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int OFF_DIR   = 0;
  localparam int OFF_PORT  = 1;
  localparam int OFF_LATCH = 2;
  localparam int OFF_ANA   = 3;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  ana_q
);
  logic hit_dir, hit_lat, hit_ana;

  // the port and latch offsets share one storage element
  assign hit_dir = we && (addr == ADDR_W'(OFF_DIR));
  assign hit_lat = we && ((addr == ADDR_W'(OFF_PORT)) || (addr == ADDR_W'(OFF_LATCH)));
  assign hit_ana = we && (addr == ADDR_W'(OFF_ANA));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= '1;
    end else begin
      if (hit_dir) dir_q <= wdata;
      if (hit_lat) lat_q <= wdata;
      if (hit_ana) ana_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  lat_q,
  input  logic [WIDTH-1:0]  ana_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] dig_in;
  logic [WIDTH-1:0] sel;

  // digital input buffer is off wherever the analog mask is set
  assign dig_in = pin_sync & ~ana_q;

  always_comb begin
    sel = '0;
    if      (addr == ADDR_W'(OFF_DIR))   sel = dir_q;
    else if (addr == ADDR_W'(OFF_PORT))  sel = dig_in;
    else if (addr == ADDR_W'(OFF_LATCH)) sel = lat_q;
    else if (addr == ADDR_W'(OFF_ANA))   sel = ana_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  logic [WIDTH-1:0] dir_q, lat_q, ana_q, pin_sync;

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_rdmux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .dir_q(dir_q), .lat_q(lat_q),
    .ana_q(ana_q), .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  ana_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(0)) |=> (pad_oe == ~$past(bus_wdata)));

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(2)))
      |=> (pad_out == $past(bus_wdata)));

  // R4
  latch_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(2)) |=> (bus_rdata == $past(pad_out)));

  // R6
  analog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(1)) |=> ((bus_rdata & $past(ana_q)) == '0));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr >= ADDR_W'(4)) |=> (bus_rdata == '0));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr >= ADDR_W'(4)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .ana_q(ana_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out, pad_oe;
  logic [7:0] ext = '0;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  // pad model: driven pins follow the block, others follow the outside level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // vectors: {dir, latch, analog, external}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h00_A5_00_FF,
    32'hFF_A5_00_3C,
    32'h38_07_00_F0,
    32'h0F_AA_F0_55,
    32'h00_FF_FF_00,
    32'hF0_0F_0F_AA
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    @(negedge clk); rst = 1'b0;
    rd(3'd0, r); check("R1 dir reset", r, 8'hFF);
    rd(3'd3, r); check("R1 ana reset", r, 8'hFF);
    rd(3'd2, r); check("R1 latch reset", r, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] d, l, a, e, pin;
      {d, l, a, e} = VEC[i];
      ext = e;
      wr(3'd3, a);
      wr((i % 2 == 0) ? 3'd1 : 3'd2, l);  // R3 both offsets load the latch
      wr(3'd0, d);
      check("R2 oe", pad_oe, ~d);
      check("R3 out", pad_out, l);
      repeat (3) @(negedge clk);
      pin = (~d & l) | (d & e);
      rd(3'd1, r); check("R5/R6 port read", r, pin & ~a);
      rd(3'd2, r); check("R4 latch read", r, l);
      rd(3'd0, r); check("R7 dir read", r, d);
      rd(3'd3, r); check("R7 ana read", r, a);
    end

    // R8 unmapped offsets
    wr(3'd0, 8'h0F); wr(3'd2, 8'h3C); wr(3'd3, 8'h00);
    for (int k = 4; k < 8; k++) begin
      wr(3'(k), 8'hC3);
      rd(3'(k), r); check("R8 unmapped read", r, 8'h00);
    end
    rd(3'd0, r); check("R8 dir kept", r, 8'h0F);
    rd(3'd2, r); check("R8 latch kept", r, 8'h3C);
    rd(3'd3, r); check("R8 ana kept", r, 8'h00);
    check("R8 oe kept", pad_oe, 8'hF0);

    // R5 synchronizer latency: two stages plus registered read
    wr(3'd0, 8'hFF); ext = 8'h00;
    @(negedge clk); bus_addr = 3'd1;
    repeat (4) @(negedge clk);
    ext = 8'h5A;
    @(posedge clk); #1; check("R5 edge+1", bus_rdata, 8'h00);
    @(posedge clk); #1; check("R5 edge+2", bus_rdata, 8'h00);
    @(posedge clk); #1; check("R5 edge+3", bus_rdata, 8'h5A);

    // R6 analog mask on driven pins
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hC3);
    repeat (3) @(negedge clk);
    rd(3'd1, r); check("R6 driven but analog", r, 8'h3C);

    // R9 read-modify-write with pins pulled low from outside (modelled as inputs)
    wr(3'd3, 8'h00); wr(3'd2, 8'h81); wr(3'd0, 8'hFF); ext = 8'h00;
    repeat (3) @(negedge clk);
    rd(3'd1, r); check("R9 pins low", r, 8'h00);
    rd(3'd2, r);
    wr(3'd2, r | 8'h10);
    rd(3'd2, r); check("R9 rmw keeps bits", r, 8'h91);
    check("R9 out", pad_out, 8'h91);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule